// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. It generates the serial clock from the system clock and drives the bidirectional data line through a separate output value and output enable. It receives the line value on its own input. After reset it runs a fixed connect sequence on its own. After that it waits for commands. Each command runs one register transaction on the remote debug port. A transaction is a read or a write, targets either the debug-port or access-port register bank, and selects one of four word registers.

A command carries its fields on the `cmd_*` pins and follows valid/ready rules. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole of a transaction and for the connect sequence. A requester may hold `cmd_valid` high through that time, or drop it. The block never stores a command it has not taken. The result has no back-pressure. `done` pulses for one cycle, and `status` and `rdata` are valid in that cycle. The serial clock runs at one bit per `2*clk_half` system cycles.

Top module: `swd_host`

## Requirements
- R1: After reset the block drives, without any command, 64 ones, 64 zeros, 64 ones, the 16-bit value 0x79E7 most significant bit first, 64 ones and 64 zeros (336 bits). `busy` then falls and no `done` pulse is given.
- R2: Every transaction starts with an 8-bit driven request, in this order: 1, port select (1 = access port), direction (1 = read), addr[0], addr[1], the XOR of those four fields, 0, 1. A debug-port read of address 0 is therefore 1,0,1,0,0,1,0,1.
- R3: A read releases the line after the request and samples 3 acknowledge bits. On OK it samples 32 data bits, least significant first, then 3 trailing bits. It then drives 16 low bits. `rdata` holds the word at `done`.
- R4: The acknowledge is decoded in arrival order. 1,0,0 is OK; 0,1,0 is WAIT; 0,0,1 is FAULT; any other pattern is a protocol error. Any result other than OK ends the transaction at once after the acknowledge window. The `status` codes are 0 OK, 1 WAIT, 2 FAULT, 3 protocol error and 4 parity error.
- R5: On a read, the first trailing bit is the parity of the data. If it is not equal to the XOR of the 32 data bits, the transaction ends with status 4 and drives no low tail.
- R6: A write releases the line for 5 bits after the request and decodes the first three of them as the acknowledge. On OK it drives 32 data bits, least significant first, then their XOR, then 15 low bits.
- R7: A write with `cmd_skip_ack` set clocks through the 5 released bits without decoding them. It always goes on with the data phase and ends with status 0.
- R8: Each bit lasts `2*clk_half` system cycles, with SWCLK low for the first half and high for the second half. Driven data and the output enable change only while SWCLK is low. Sampled bits are taken as SWCLK falls.
- R9: Whenever `busy` is low, SWCLK is low and the data line is driven low.
- R10: A command is taken only while `cmd_ready` is high. A `cmd_valid` that is dropped before `cmd_ready` rises has no effect. `done` is a single-cycle pulse given while `busy` is high, and `busy` falls in the next cycle.
- R11: While reset is asserted, SWCLK is low, `done` is low and `cmd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_half | input | DIVW | System cycles per SWCLK half-period (0 acts as 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_ap | input | 1 | 1 = access-port bank, 0 = debug-port bank |
| cmd_addr | input | 2 | Register select within the bank |
| cmd_wdata | input | DW | Write word |
| cmd_skip_ack | input | 1 | Write only: do not decode the acknowledge |
| busy | output | 1 | Connect sequence or transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 3 | Result code, valid with `done` |
| rdata | output | DW | Read word, valid with `done` after an OK read |
| swclk | output | 1 | Serial clock to the target |
| swdio_out | output | 1 | Data value driven onto the line |
| swdio_oe | output | 1 | 1 = host drives the line |
| swdio_in | input | 1 | Line value seen by the host |

## Verification
The properties assume three things about the inputs. `clk_half` changes only while `busy` is low. `swdio_in` needs to be stable only around the falling SWCLK edges where it is sampled. The target may change it at any other time. The bench changes `clk_half` only between transactions. Its target model updates `swdio_in` just after each rising SWCLK edge of a released bit, which is half a bit before the sample. The bench drops the command it issues while the engine is busy before that transaction ends, so that no command is pending when `cmd_ready` returns.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_WAIT   = 3'd1,
    ST_FAULT  = 3'd2,
    ST_PROTO  = 3'd3,
    ST_PARITY = 3'd4
  } swd_status_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_CONN,
    PH_HDR,
    PH_ACK,
    PH_RDATA,
    PH_RTAIL,
    PH_WDATA,
    PH_TRAIL,
    PH_DONE
  } swd_phase_e;

  localparam int RST_RUN   = 64;
  localparam logic [15:0] SWITCH_PAT = 16'h79E7;
  localparam int SW_BITS   = 16;
  localparam int SEG_ZERO1 = RST_RUN;
  localparam int SEG_ONE2  = 2 * RST_RUN;
  localparam int SEG_SW    = 3 * RST_RUN;
  localparam int SEG_ONE3  = SEG_SW + SW_BITS;
  localparam int SEG_ZERO3 = SEG_ONE3 + RST_RUN;
  localparam int CONN_LEN  = SEG_ZERO3 + RST_RUN;
  localparam int HDR_LEN   = 8;
  localparam int ACK_RD    = 3;
  localparam int ACK_WR    = 5;
  localparam int RTAIL_LEN = 3;
  localparam int TRAIL_RD  = 16;
  localparam int TRAIL_WR  = 15;
  localparam int IW        = $clog2(CONN_LEN);

  // Request byte, sent from bit 7 down to bit 0.
  function automatic logic [7:0] make_request(input logic ap, input logic rnw,
                                              input logic [1:0] a);
    logic par;
    par = ap ^ rnw ^ a[0] ^ a[1];
    return {1'b1, ap, rnw, a[0], a[1], par, 1'b0, 1'b1};
  endfunction

  function automatic logic conn_bit(input logic [IW-1:0] i);
    int k;
    k = int'(i);
    if (k < SEG_ZERO1)      return 1'b1;
    else if (k < SEG_ONE2)  return 1'b0;
    else if (k < SEG_SW)    return 1'b1;
    else if (k < SEG_ONE3)  return SWITCH_PAT[SW_BITS-1-(k-SEG_SW)];
    else if (k < SEG_ZERO3) return 1'b1;
    else                    return 1'b0;
  endfunction

  // v[0] is the first bit to arrive.
  function automatic swd_status_e decode_ack(input logic [2:0] v);
    case (v)
      3'b001:  return ST_OK;
      3'b010:  return ST_WAIT;
      3'b100:  return ST_FAULT;
      default: return ST_PROTO;
    endcase
  endfunction

endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] half,
  output logic            swclk,
  output logic            bit_end
);
  logic [DIVW-1:0] cnt;
  logic            hi;
  logic [DIVW-1:0] eff;
  logic            wrap;

  assign eff     = (half == '0) ? DIVW'(1) : half;
  assign wrap    = (cnt == eff - DIVW'(1));
  assign bit_end = run && hi && wrap;
  assign swclk   = hi;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      hi  <= ~hi;
    end else begin
      cnt <= cnt + DIVW'(1);
    end
  end
endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture #(
  parameter int DW = 32,
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          din,
  input  logic          take_ack,
  input  logic          take_data,
  input  logic          take_par,
  input  logic [IW-1:0] idx,
  output logic [2:0]    ack_q,
  output logic [DW-1:0] data_q,
  output logic          par_q
);
  localparam int DIW = $clog2(DW);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ack_q  <= '0;
      data_q <= '0;
      par_q  <= 1'b0;
    end else begin
      if (take_ack && idx < IW'(3)) ack_q[idx[1:0]] <= din;
      if (take_data)                data_q[idx[DIW-1:0]] <= din;
      if (take_par)                 par_q <= din;
    end
  end
endmodule

// File: rtl/swd_tx_mux.sv
module swd_tx_mux
  import swd_pkg::*;
#(
  parameter int DW = 32
) (
  input  swd_phase_e    phase,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    req,
  input  logic [DW-1:0] wdata,
  output logic          drive,
  output logic          bit_o
);
  localparam int DIW = $clog2(DW);

  always_comb begin
    drive = 1'b1;
    bit_o = 1'b0;
    case (phase)
      PH_CONN:  bit_o = conn_bit(idx);
      PH_HDR:   bit_o = req[3'd7 - idx[2:0]];
      PH_WDATA: bit_o = (idx < IW'(DW)) ? wdata[idx[DIW-1:0]] : ^wdata;
      PH_ACK, PH_RDATA, PH_RTAIL: drive = 1'b0;
      default:  bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/swd_host.sv
module swd_host
  import swd_pkg::*;
#(
  parameter int DIVW = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] clk_half,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_write,
  input  logic            cmd_ap,
  input  logic [1:0]      cmd_addr,
  input  logic [DW-1:0]   cmd_wdata,
  input  logic            cmd_skip_ack,
  output logic            busy,
  output logic            done,
  output logic [2:0]      status,
  output logic [DW-1:0]   rdata,
  output logic            swclk,
  output logic            swdio_out,
  output logic            swdio_oe,
  input  logic            swdio_in
);
  swd_phase_e    ph;
  swd_status_e   st;
  logic [IW-1:0] idx;
  logic [IW-1:0] seg_len;
  logic          is_wr, skip;
  logic [7:0]    req_q;
  logic [DW-1:0] wdata_q;
  logic          run, bit_end, seg_last, accept;
  logic [2:0]    ack_q, ackv;
  logic [DW-1:0] data_q;
  logic          par_q;
  swd_status_e   ack_st;

  assign accept = (ph == PH_IDLE) && cmd_valid;
  assign run    = (ph != PH_IDLE) && (ph != PH_DONE);

  swd_bit_timer #(.DIVW(DIVW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .half(clk_half),
    .swclk(swclk), .bit_end(bit_end)
  );

  swd_rx_capture #(.DW(DW), .IW(IW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(accept), .din(swdio_in),
    .take_ack(bit_end && ph == PH_ACK),
    .take_data(bit_end && ph == PH_RDATA),
    .take_par(bit_end && ph == PH_RTAIL && idx == '0),
    .idx(idx), .ack_q(ack_q), .data_q(data_q), .par_q(par_q)
  );

  swd_tx_mux #(.DW(DW)) u_tx (
    .phase(ph), .idx(idx), .req(req_q), .wdata(wdata_q),
    .drive(swdio_oe), .bit_o(swdio_out)
  );

  always_comb begin
    case (ph)
      PH_CONN:  seg_len = IW'(CONN_LEN);
      PH_HDR:   seg_len = IW'(HDR_LEN);
      PH_ACK:   seg_len = is_wr ? IW'(ACK_WR) : IW'(ACK_RD);
      PH_RDATA: seg_len = IW'(DW);
      PH_RTAIL: seg_len = IW'(RTAIL_LEN);
      PH_WDATA: seg_len = IW'(DW + 1);
      PH_TRAIL: seg_len = is_wr ? IW'(TRAIL_WR) : IW'(TRAIL_RD);
      default:  seg_len = IW'(1);
    endcase
  end

  assign seg_last = bit_end && (idx == seg_len - IW'(1));
  // A read decides on its third ack bit, which is still on the input.
  assign ackv   = is_wr ? ack_q : {swdio_in, ack_q[1:0]};
  assign ack_st = decode_ack(ackv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_CONN;
      idx     <= '0;
      is_wr   <= 1'b0;
      skip    <= 1'b0;
      req_q   <= '0;
      wdata_q <= '0;
      st      <= ST_OK;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (accept) begin
            ph      <= PH_HDR;
            idx     <= '0;
            is_wr   <= cmd_write;
            skip    <= cmd_skip_ack & cmd_write;
            req_q   <= make_request(cmd_ap, ~cmd_write, cmd_addr);
            wdata_q <= cmd_wdata;
          end
        end
        PH_DONE: ph <= PH_IDLE;
        default: begin
          if (seg_last) begin
            idx <= '0;
            case (ph)
              PH_CONN: ph <= PH_IDLE;
              PH_HDR:  ph <= PH_ACK;
              PH_ACK: begin
                if (skip)                ph <= PH_WDATA;
                else if (ack_st != ST_OK) begin
                  st <= ack_st;
                  ph <= PH_DONE;
                end
                else if (is_wr)          ph <= PH_WDATA;
                else                     ph <= PH_RDATA;
              end
              PH_RDATA: ph <= PH_RTAIL;
              PH_RTAIL: begin
                if (par_q != ^data_q) begin
                  st <= ST_PARITY;
                  ph <= PH_DONE;
                end else begin
                  ph <= PH_TRAIL;
                end
              end
              PH_WDATA: ph <= PH_TRAIL;
              PH_TRAIL: begin
                st <= ST_OK;
                ph <= PH_DONE;
              end
              default: ph <= PH_IDLE;
            endcase
          end else if (bit_end) begin
            idx <= idx + IW'(1);
          end
        end
      endcase
    end
  end

  assign cmd_ready = (ph == PH_IDLE);
  assign busy      = (ph != PH_IDLE);
  assign done      = (ph == PH_DONE);
  assign status    = st;
  assign rdata     = data_q;
endmodule

// File: rtl/swd_host_chk.sv
module swd_host_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [2:0]    status,
  input logic          swclk,
  input logic          swdio_out,
  input logic          swdio_oe
);
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!swclk && swdio_oe && !swdio_out)); // R9
  AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe))); // R8
  AST_OE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(swdio_oe) |-> !swclk); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R10
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R10
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status <= 3'd4)); // R4
endmodule

bind swd_host swd_host_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .status(status),
  .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe)
);

// File: tb/swd_host_test.sv
`timescale 1ns/1ps
module swd_host_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_half = 8'd2;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_ap = 1'b0, cmd_skip_ack = 1'b0;
  logic [1:0]  cmd_addr = 2'd0;
  logic [31:0] cmd_wdata = '0;
  logic        swdio_in = 1'b0;
  logic        cmd_ready, busy, done, swclk, swdio_out, swdio_oe;
  logic [2:0]  status;
  logic [31:0] rdata;

  swd_host uut (
    .clk(clk), .rst_n(rst_n), .clk_half(clk_half), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_ap(cmd_ap),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_skip_ack(cmd_skip_ack),
    .busy(busy), .done(done), .status(status), .rdata(rdata),
    .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, last_rise = -1;
  bit finished = 0;
  logic  exp_oe[$], exp_bit[$], rsp[$];
  string exp_tag[$];
  logic  swclk_prev = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void push(input logic oe, input logic b, input string tag);
    exp_oe.push_back(oe); exp_bit.push_back(b); exp_tag.push_back(tag);
  endfunction

  // Reference line model: one expected slot per rising SWCLK edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (swclk && !swclk_prev) begin
        if (exp_oe.size() == 0) begin
          chk("R8 unexpected edge", 32'd1, 32'd0);
        end else begin
          logic e_oe, e_b; string t;
          e_oe = exp_oe.pop_front(); e_b = exp_bit.pop_front(); t = exp_tag.pop_front();
          chk({t, " oe"}, {31'd0, swdio_oe}, {31'd0, e_oe});
          if (e_oe) chk({t, " bit"}, {31'd0, swdio_out}, {31'd0, e_b});
          else swdio_in = (rsp.size() > 0) ? rsp.pop_front() : 1'b0;
        end
        if (busy && last_rise >= 0) chk("R8 bit period", cyc - last_rise, 2 * clk_half);
        last_rise = cyc;
      end
      if (!busy) last_rise = -1;
    end
    swclk_prev = swclk;
  end

  task automatic push_req(input bit ap, input bit rnw, input bit [1:0] a);
    bit p;
    p = ap ^ rnw ^ a[0] ^ a[1];
    push(1, 1, "R2"); push(1, ap, "R2"); push(1, rnw, "R2"); push(1, a[0], "R2");
    push(1, a[1], "R2"); push(1, p, "R2"); push(1, 0, "R2"); push(1, 1, "R2");
  endtask

  task automatic issue(input bit wr, input bit ap, input bit [1:0] a,
                       input bit [31:0] d, input bit skip);
    @(negedge clk);
    chk("R10 ready before command", {31'd0, cmd_ready}, 32'd1);
    cmd_valid = 1; cmd_write = wr; cmd_ap = ap; cmd_addr = a;
    cmd_wdata = d; cmd_skip_ack = skip;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic finish_txn(input string tag, input bit [2:0] st,
                            input bit chk_rd, input bit [31:0] d);
    int n;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk({tag, " done seen"}, {31'd0, done}, 32'd1);
    chk({tag, " status"}, {29'd0, status}, {29'd0, st});
    if (chk_rd) chk({tag, " rdata"}, rdata, d);
    chk({tag, " all bits sent"}, exp_oe.size(), 0);
    @(negedge clk);
    chk("R10 busy falls after done", {30'd0, busy, done}, 32'd0);
    exp_oe.delete(); exp_bit.delete(); exp_tag.delete(); rsp.delete();
  endtask

  task automatic do_read(input string tag, input bit ap, input bit [1:0] a,
                         input bit [2:0] ack, input bit [31:0] d,
                         input bit badpar, input bit [2:0] st);
    rsp.delete();
    push_req(ap, 1, a);
    for (int i = 0; i < 3; i++) begin push(0, 0, "R3 ack"); rsp.push_back(ack[i]); end
    if (ack == 3'b001) begin
      for (int i = 0; i < 32; i++) begin push(0, 0, "R3 data"); rsp.push_back(d[i]); end
      push(0, 0, "R5 parity"); rsp.push_back((^d) ^ badpar);
      push(0, 0, "R3 tail"); rsp.push_back(0);
      push(0, 0, "R3 tail"); rsp.push_back(0);
      if (!badpar) for (int i = 0; i < 16; i++) push(1, 0, "R3 idle");
    end
    issue(0, ap, a, 32'd0, 0);
    finish_txn(tag, st, st == 3'd0, d);
  endtask

  task automatic do_write(input string tag, input bit ap, input bit [1:0] a,
                          input bit [2:0] ack, input bit [31:0] d,
                          input bit skip, input bit [2:0] st, input bit inject);
    rsp.delete();
    push_req(ap, 0, a);
    for (int i = 0; i < 5; i++) begin
      push(0, 0, "R6 ack window"); rsp.push_back(i < 3 ? ack[i] : 1'b0);
    end
    if (skip || ack == 3'b001) begin
      for (int i = 0; i < 32; i++) push(1, d[i], "R6 data");
      push(1, ^d, "R6 parity");
      for (int i = 0; i < 15; i++) push(1, 0, "R6 idle");
    end
    issue(1, ap, a, d, skip);
    if (inject) begin
      repeat (40) @(negedge clk);
      chk("R10 not ready while busy", {31'd0, cmd_ready}, 32'd0);
      cmd_valid = 1; cmd_write = 0; cmd_ap = 1; cmd_addr = 2'd3;
      repeat (3) @(negedge clk);
      cmd_valid = 0;
    end
    finish_txn(tag, st, 0, 32'd0);
  endtask

  initial begin
    // R1 expected connect sequence.
    for (int i = 0; i < 64; i++) push(1, 1, "R1");
    for (int i = 0; i < 64; i++) push(1, 0, "R1");
    for (int i = 0; i < 64; i++) push(1, 1, "R1");
    for (int i = 15; i >= 0; i--) push(1, 16'h79E7 >> i, "R1");
    for (int i = 0; i < 64; i++) push(1, 1, "R1");
    for (int i = 0; i < 64; i++) push(1, 0, "R1");
    repeat (4) @(negedge clk);
    chk("R11 reset swclk/done/ready", {29'd0, swclk, done, cmd_ready}, 32'd0);
    rst_n = 1;
    begin
      int n; n = 0;
      while (busy && n < 20000) begin @(negedge clk); n++; end
    end
    chk("R1 connect length", exp_oe.size(), 0);
    chk("R1 no done after connect", {31'd0, done}, 32'd0);
    exp_oe.delete(); exp_bit.delete(); exp_tag.delete();
    repeat (5) @(negedge clk);
    chk("R9 idle line", {29'd0, swclk, swdio_oe, swdio_out}, 32'b010);

    do_read ("R3 read dp0",        0, 2'd0, 3'b001, 32'h1234_5678, 0, 3'd0);
    do_read ("R3 read ap3",        1, 2'd3, 3'b001, 32'hFFFF_FFFF, 0, 3'd0);
    do_read ("R4 read wait",       0, 2'd1, 3'b010, 32'h0,         0, 3'd1);
    do_read ("R4 read fault",      1, 2'd2, 3'b100, 32'h0,         0, 3'd2);
    do_read ("R4 read proto 110",  0, 2'd2, 3'b011, 32'h0,         0, 3'd3);
    do_read ("R4 read proto 000",  0, 2'd0, 3'b000, 32'h0,         0, 3'd3);
    do_read ("R5 read bad parity", 1, 2'd1, 3'b001, 32'h8000_0001, 1, 3'd4);
    do_write("R6 write ap1",       1, 2'd1, 3'b001, 32'hA5A5_0F0F, 0, 3'd0, 0);
    do_write("R4 write wait",      0, 2'd2, 3'b010, 32'h1111_2222, 0, 3'd1, 0);
    do_write("R7 write skip ack",  0, 2'd3, 3'b000, 32'h7654_3210, 1, 3'd0, 0);
    clk_half = 8'd3;
    do_write("R10 write with stray command", 1, 2'd0, 3'b001, 32'hDEAD_BEEF, 0, 3'd0, 1);
    do_read ("R8 read at slower clock", 0, 2'd1, 3'b001, 32'h0000_0003, 0, 3'd0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i % 10 == 0)
        chk("R10 stray command not taken", {28'd0, busy, swclk, swdio_oe, swdio_out}, 32'b0010);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule